// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Strobe Controller

This block sits between a synchronous requester and an external asynchronous static RAM with a byte-wide data bus. It accepts one single-word read or write request at a time. It then runs the active-low chip enable, output enable and write enable lines through a fixed sequence, and it drives the address and a tri-state enable for the data pins. Every interval in the sequence is a whole number of system clock cycles, and each interval is set by a parameter. Read data is registered at the end of the access and returned with a one-cycle valid pulse.

The requester picks, for each request, which strobe ends a write: write enable rising while chip enable stays low, or chip enable rising while write enable stays low. By default the controller keeps output enable low when the bus is idle and during reads. This shortens later reads. It also means that every write must wait out a turnaround interval, from the fall of write enable until the controller's data drivers switch on, so that the RAM's outputs have time to release the bus.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after release, chip enable and write enable are high (inactive), the data drivers are off, busy_o and rvalid_o are low, and output enable is low (the parked state).
- R2: A read request accepted on a clock edge drives chip enable and output enable low and write enable high from that edge. These levels last for exactly max(T_ADDR_ACC, T_CE_ACC, T_OE_ACC, T_RD_CYCLE) cycles, which is 4 with the default parameters.
- R3: sram_dq_i is sampled on the edge that ends the last read strobe cycle. On that same edge rdata_o takes the sampled value and rvalid_o goes high for exactly one cycle. rdata_o then holds until the next read completes.
- R4: When req_wr_i=1 and ce_end_i=0, chip enable and write enable fall together on the accept edge. Write enable rises T_TURN+T_WR_PULSE cycles later while chip enable is still low, and chip enable rises one cycle after that.
- R5: When req_wr_i=1 and ce_end_i=1, both strobes fall together on the accept edge. Chip enable rises T_TURN+T_WR_PULSE cycles later while write enable is still low, and write enable rises one cycle after that.
- R6: In a write with output enable parked, sram_dq_oe_o stays low for T_TURN cycles after write enable falls. It is then high for T_WR_PULSE cycles with sram_dq_o equal to the request data, and it drops on the same edge as the terminating strobe.
- R7: Output enable is low while idle and during reads. It is high only in the single cycle that follows the terminating strobe of a write.
- R8: A request raised while busy_o is high is ignored. The strobe sequence, the address, busy_o and the data pins are unchanged, and no cycle starts once the current one ends.
- R9: sram_addr_o and sram_dq_o hold the accepted address and data from the accept edge until the controller returns to idle, which is one cycle after the terminating strobe. busy_o stays high for that whole span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, accepted only when idle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Word address |
| req_wdata_i | input | 8 | Write data |
| ce_end_i | input | 1 | 1 = chip enable ends the write, 0 = write enable ends it |
| busy_o | output | 1 | High from accept until return to idle |
| rdata_o | output | 8 | Last captured read data |
| rvalid_o | output | 1 | One-cycle pulse when rdata_o is updated |
| sram_addr_o | output | 19 | RAM address |
| sram_ce_no | output | 1 | RAM chip enable, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_we_no | output | 1 | RAM write enable, active low |
| sram_dq_o | output | 8 | Data toward the RAM pins |
| sram_dq_oe_o | output | 1 | Tri-state enable for sram_dq_o |
| sram_dq_i | input | 8 | Data from the RAM pins |

## Verification
Two events can land on the same clock edge: a new request being sampled, and the controller capturing read data or leaving its hold cycle. The bench provokes this by holding req_i high, with a different address and the opposite direction, across the capture edge and the following hold edge of a read. It then compares every strobe, the address, busy_o and the driver enable against the undisturbed read timeline, and it confirms that no write starts afterwards. The RAM model in the bench returns valid data only after the access count has run out, so a capture that comes too early shows up as a wrong data value.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_HOLD
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (load_i)             cnt_next_o = load_val_i;
    else if (cnt_q != '0)   cnt_next_o = cnt_q - 1'b1;
    else                    cnt_next_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_next_o;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_LEN  = 4,
  parameter int unsigned WR_LEN  = 5,
  parameter int unsigned DRV_AT  = 2,
  parameter bit          OE_PARK = 1'b1,
  parameter int unsigned CNT_W   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic wr_i,
  input  logic cet_i,
  output logic busy_o,
  output logic accept_o,
  output logic capture_o,
  output logic ce_n_o,
  output logic oe_n_o,
  output logic we_n_o,
  output logic dq_oe_o
);

  seq_state_e       state_q, state_d;
  logic             wr_q, wr_d, cet_q, cet_d;
  logic             load;
  logic [CNT_W-1:0] load_val, cnt_d;
  logic             zero;
  logic             ce_n_d, oe_n_d, we_n_d, dq_oe_d;
  logic             ce_n_q, oe_n_q, we_n_q, dq_oe_q;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .cnt_next_o (cnt_d),
    .zero_o     (zero)
  );

  always_comb begin
    state_d   = state_q;
    wr_d      = wr_q;
    cet_d     = cet_q;
    load      = 1'b0;
    load_val  = '0;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        wr_d     = wr_i;
        cet_d    = cet_i;
        load     = 1'b1;
        load_val = wr_i ? CNT_W'(WR_LEN - 1) : CNT_W'(RD_LEN - 1);
        state_d  = wr_i ? ST_WRITE : ST_READ;
      end
      ST_READ: if (zero) begin
        capture_o = 1'b1;
        state_d   = ST_HOLD;
      end
      ST_WRITE: if (zero) state_d = ST_HOLD;
      ST_HOLD:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // non-terminating strobe lingers one cycle in the hold state
  assign ce_n_d  = !((state_d == ST_READ) || (state_d == ST_WRITE) ||
                     ((state_d == ST_HOLD) && wr_d && !cet_d));
  assign we_n_d  = !((state_d == ST_WRITE) || ((state_d == ST_HOLD) && wr_d && cet_d));
  assign dq_oe_d = (state_d == ST_WRITE) && (cnt_d <= CNT_W'(DRV_AT));

  generate
    if (OE_PARK) begin : g_oe_park
      assign oe_n_d = (state_d == ST_HOLD) && wr_d;
    end else begin : g_oe_read_only
      assign oe_n_d = (state_d != ST_READ);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      cet_q   <= 1'b0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= !OE_PARK;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      cet_q   <= cet_d;
      ce_n_q  <= ce_n_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      dq_oe_q <= dq_oe_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign ce_n_o  = ce_n_q;
  assign oe_n_o  = oe_n_q;
  assign we_n_o  = we_n_q;
  assign dq_oe_o = dq_oe_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (ce_n_q && we_n_q && !dq_oe_q));

  // R6
  drv_in_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_q |-> (!we_n_q && !ce_n_q));

  // R2
  read_levels_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ) |-> (we_n_q && !ce_n_q && !oe_n_q));

  // R4
  we_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(we_n_q) && wr_q && !cet_q) |-> !ce_n_q);

  // R5
  ce_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ce_n_q) && wr_q && cet_q) |-> !we_n_q);

  generate
    if (OE_PARK) begin : g_turn_chk
      // R6
      turn_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(we_n_q) |-> !dq_oe_q);
    end
  endgenerate

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= capture_i;
      if (capture_i) rdata_o <= mem_dq_i;
    end
  end

  // R3
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned T_ADDR_ACC = 3,
  parameter int unsigned T_CE_ACC   = 3,
  parameter int unsigned T_OE_ACC   = 2,
  parameter int unsigned T_RD_CYCLE = 4,
  parameter int unsigned T_WR_PULSE = 3,
  parameter int unsigned T_TURN     = 2,
  parameter bit          OE_PARK    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              ce_end_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned RD_LEN   = max2(max2(T_ADDR_ACC, T_CE_ACC), max2(T_OE_ACC, T_RD_CYCLE));
  localparam int unsigned TURN_EFF = OE_PARK ? T_TURN : 0;
  localparam int unsigned WR_LEN   = TURN_EFF + T_WR_PULSE;
  localparam int unsigned DRV_AT   = T_WR_PULSE - 1;
  localparam int unsigned CNT_W    = $clog2(max2(RD_LEN, WR_LEN) + 1);

  logic accept, capture;

  sram_strobe_seq #(
    .RD_LEN  (RD_LEN),
    .WR_LEN  (WR_LEN),
    .DRV_AT  (DRV_AT),
    .OE_PARK (OE_PARK),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .wr_i      (req_wr_i),
    .cet_i     (ce_end_i),
    .busy_o    (busy_o),
    .accept_o  (accept),
    .capture_o (capture),
    .ce_n_o    (sram_ce_no),
    .oe_n_o    (sram_oe_no),
    .we_n_o    (sram_we_no),
    .dq_oe_o   (sram_dq_oe_o)
  );

  sram_data_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .capture_i (capture),
    .mem_dq_i  (sram_dq_i),
    .addr_o    (sram_addr_o),
    .wdata_o   (sram_dq_o),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(sram_addr_o) && $stable(sram_dq_o)));

  // R8
  no_start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(busy_o)) |-> ($past(sram_ce_no) && $past(sram_we_no)));

endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;

  localparam int RD_LEN = 4;
  localparam int WR_LEN = 5;
  localparam int TURN   = 2;
  localparam int ACC    = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_wr = 1'b0, ce_end = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, rvalid, ce_n, oe_n, we_n, dq_oe;
  logic [7:0]  rdata, dq_o, dq_i;
  logic [18:0] s_addr;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sram_ctrl #(
    .T_ADDR_ACC(3), .T_CE_ACC(3), .T_OE_ACC(2), .T_RD_CYCLE(4),
    .T_WR_PULSE(3), .T_TURN(2), .OE_PARK(1'b1)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_wr_i(req_wr),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ce_end_i(ce_end),
    .busy_o(busy), .rdata_o(rdata), .rvalid_o(rvalid),
    .sram_addr_o(s_addr), .sram_ce_no(ce_n), .sram_oe_no(oe_n),
    .sram_we_no(we_n), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe),
    .sram_dq_i(dq_i)
  );

  // RAM model: data valid only after ACC cycles of an active read
  logic [7:0] mem [16];
  logic [7:0] exp_mem [16];
  logic [3:0] acc_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'(i * 17 + 3);
      acc_cnt <= '0;
    end else begin
      acc_cnt <= (!ce_n && !oe_n && we_n) ? acc_cnt + 4'd1 : 4'd0;
      if (!ce_n && !we_n && dq_oe) mem[s_addr[3:0]] <= dq_o;
    end
  end

  assign dq_i = (!ce_n && !oe_n && we_n && acc_cnt >= 4'(ACC)) ? mem[s_addr[3:0]] : 8'hEE;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // trace of outputs, sampled at the negedge after accept edge + n
  logic t_ce[8], t_oe[8], t_we[8], t_drv[8], t_busy[8], t_rv[8];
  logic [18:0] t_addr[8];
  logic [7:0]  t_dq[8], t_rd[8];

  task automatic run_op(input logic wr, input logic cet, input logic [18:0] a,
                        input logic [7:0] d, input bit poke);
    @(negedge clk);
    req = 1'b1; req_wr = wr; ce_end = cet; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; req_addr = ~a; req_wdata = ~d;
    for (int n = 0; n < 8; n++) begin
      if (n > 0) @(negedge clk);
      t_ce[n] = ce_n; t_oe[n] = oe_n; t_we[n] = we_n; t_drv[n] = dq_oe;
      t_busy[n] = busy; t_rv[n] = rvalid; t_addr[n] = s_addr;
      t_dq[n] = dq_o; t_rd[n] = rdata;
      if (poke && n == 3) begin req = 1'b1; req_wr = ~wr; end
      if (poke && n == 5) req = 1'b0;
    end
  endtask

  task automatic check_read(input logic [18:0] a, input logic [7:0] exp_d);
    for (int n = 0; n < 8; n++) begin
      check($sformatf("R2 ce_n n=%0d", n), 32'(t_ce[n]), 32'(n >= RD_LEN));
      check($sformatf("R2 we_n n=%0d", n), 32'(t_we[n]), 32'd1);
      check($sformatf("R7 oe_n n=%0d", n), 32'(t_oe[n]), 32'd0);
      check($sformatf("R6 drv n=%0d", n),  32'(t_drv[n]), 32'd0);
      check($sformatf("R9 busy n=%0d", n), 32'(t_busy[n]), 32'(n <= RD_LEN));
      check($sformatf("R3 rvalid n=%0d", n), 32'(t_rv[n]), 32'(n == RD_LEN));
      if (n <= RD_LEN) check($sformatf("R9 addr n=%0d", n), 32'(t_addr[n]), 32'(a));
    end
    check("R3 rdata", 32'(t_rd[RD_LEN]), 32'(exp_d));
    check("R3 rdata held", 32'(t_rd[7]), 32'(exp_d));
  endtask

  task automatic check_write(input logic cet, input logic [18:0] a, input logic [7:0] d);
    for (int n = 0; n < 8; n++) begin
      logic term_n, other_n;
      term_n  = (n >= WR_LEN);
      other_n = (n >= WR_LEN + 1);
      if (!cet) begin
        check($sformatf("R4 we_n n=%0d", n), 32'(t_we[n]), 32'(term_n));
        check($sformatf("R4 ce_n n=%0d", n), 32'(t_ce[n]), 32'(other_n));
      end else begin
        check($sformatf("R5 ce_n n=%0d", n), 32'(t_ce[n]), 32'(term_n));
        check($sformatf("R5 we_n n=%0d", n), 32'(t_we[n]), 32'(other_n));
      end
      check($sformatf("R6 drv n=%0d", n), 32'(t_drv[n]), 32'(n >= TURN && n < WR_LEN));
      check($sformatf("R7 oe_n n=%0d", n), 32'(t_oe[n]), 32'(n == WR_LEN));
      check($sformatf("R9 busy n=%0d", n), 32'(t_busy[n]), 32'(n <= WR_LEN));
      if (n <= WR_LEN) begin
        check($sformatf("R9 addr n=%0d", n), 32'(t_addr[n]), 32'(a));
        check($sformatf("R9 data n=%0d", n), 32'(t_dq[n]), 32'(d));
      end
    end
  endtask

  task automatic reset_test;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 ce_n in reset", 32'(ce_n), 32'd1);
    check("R1 we_n in reset", 32'(we_n), 32'd1);
    check("R1 oe_n in reset", 32'(oe_n), 32'd0);
    check("R1 drv in reset", 32'(dq_oe), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 rvalid", 32'(rvalid), 32'd0);
    check("R1 ce_n", 32'(ce_n), 32'd1);
    check("R1 we_n", 32'(we_n), 32'd1);
    for (int i = 0; i < 16; i++) exp_mem[i] = 8'(i * 17 + 3);
  endtask

  task automatic read_test(input logic [18:0] a);
    run_op(1'b0, 1'b0, a, 8'h00, 1'b0);
    check_read(a, exp_mem[a[3:0]]);
  endtask

  task automatic write_test(input logic cet, input logic [18:0] a, input logic [7:0] d);
    run_op(1'b1, cet, a, d, 1'b0);
    check_write(cet, a, d);
    exp_mem[a[3:0]] = d;
  endtask

  task automatic ignore_test(input logic [18:0] a);
    // request held across the capture edge and the hold edge
    run_op(1'b0, 1'b0, a, 8'h00, 1'b1);
    check_read(a, exp_mem[a[3:0]]);
    check("R8 no write after", 32'(t_we[6] & t_we[7]), 32'd1);
    check("R8 idle after", 32'(t_busy[6] | t_busy[7]), 32'd0);
    check("R8 addr kept", 32'(t_addr[7]), 32'(a));
  endtask

  initial begin
    reset_test();
    read_test(19'h7_0003);
    write_test(1'b0, 19'h4_1005, 8'hA5);
    read_test(19'h4_1005);
    write_test(1'b1, 19'h0_0009, 8'h3C);
    read_test(19'h0_0009);
    ignore_test(19'h2_000C);
    read_test(19'h0_0001);
    read_test(19'h7_FFF2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule